// File: doc/BRIEF.md
# Interrupt Context Capture and Vector Modifier

This block sits beside the interrupt arbiter of a two-channel serial controller. When the processor runs an interrupt acknowledge cycle, or software issues an update command, the block freezes the context of the current arbitration winner: which channel raised it, the interrupt type byte, and a byte count taken from that channel's FIFO level. The frozen context then stays readable through a small register port until the next acknowledge or update.

During the acknowledge cycle the block drives an 8-bit vector onto the data bus. The vector is built from a programmable base vector register. A 2-bit configuration level decides how many of its low bits are replaced with live interrupt information.

Two global FIFO windows in the register port are steered by the frozen context. A write to the transmit window becomes a push into the captured channel's transmit queue. A read of the receive window pops the captured channel's receive queue. A new winner at the arbiter does not move these windows until the context is captured again.

Top module: `uart_irq_ctx`

## Requirements
- R1: While `iack` is high, `vec_out` bits 7:3 equal bits 7:3 of the base vector register. With `ivc_cfg` 0 or 1, the whole vector equals the base vector register. While `iack` is low, `vec_out` is 0x00.
- R2: With `ivc_cfg` equal to 2, vector bit 0 is the winner's channel number (0 = channel a, 1 = channel b), and bits 2:1 come from the base vector register.
- R3: With `ivc_cfg` equal to 3, bit 0 is the channel number and bits 2:1 carry a type code taken from the winner's type byte: 11 for receive without errors, 10 for receive with errors, 01 for transmitter, 00 for any other interrupt.
- R4: At the clock edge that samples `iack` or `upd` high, the winner's channel, type and count are captured. The captured values hold while neither strobe is high, whatever the winner inputs do.
- R5: Address 1 reads the captured channel in bit 0. Bits 7:1 read zero.
- R6: Address 2 reads the captured type byte. Bit 7 set with bit 6 clear means receive with errors, bits 7:6 = 11 means receive without errors, and bit 7 clear means not a receiver interrupt. Bit 5 marks a transmitter interrupt. Bits 2:0 give the other-type code (0 none, 1 change of state, 2 address recognition, 3 flow-control status, 4 receive watchdog, 5 break change, 6 counter/timer, 7 loopback error). Bits 4:3 always read zero.
- R7: Address 3 reads the captured byte count. A level of 1 to 255 reads as itself and a level of 256 reads as 0x00. If the captured type is neither receiver nor transmitter, the count reads 0x00.
- R8: A write to address 5 pulses exactly the `txq_push` bit of the captured channel, with `txq_data` equal to the write data.
- R9: A read of address 4 in a receiver context returns the captured channel's receive byte and pulses only that channel's `rxq_pop` bit. In any other context it returns 0x00 and pops nothing.
- R10: Address 0 is the base vector register. It is written on a clock edge with `reg_wr` high and reads back the written value. Addresses 6 and 7 read 0x00.
- R11: After reset the base vector register reads 0x0F and the channel, type and count registers read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| win_ch | input | CH_W | Channel of the arbitration winner |
| win_type | input | 8 | Type byte of the winner |
| win_level | input | LVL_W | Winner's FIFO level (transmit empty or receive fill) |
| iack | input | 1 | Interrupt acknowledge strobe |
| upd | input | 1 | Update-context command strobe |
| ivc_cfg | input | 2 | Vector modification level |
| vec_out | output | 8 | Vector driven during acknowledge |
| vec_drive | output | 1 | High while the vector is on the bus |
| reg_sel | input | 3 | Register address |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| rxq_data | input | NUM_CH*8 | Head byte of each receive queue |
| rxq_pop | output | NUM_CH | Per-channel receive pop |
| txq_push | output | NUM_CH | Per-channel transmit push |
| txq_data | output | 8 | Byte for the transmit push |

## Verification
The embedded checks assume that the winner inputs never mark an interrupt as both receiver and transmitter. They also assume that `win_level` never exceeds the FIFO depth, and that a strobe or register access lasts a single cycle. The directed stimulus only builds type bytes from the legal receiver, transmitter and other-type encodings, and only uses levels between 0 and 256. Register accesses are raised and dropped within one clock phase, except for the vector register write, which spans exactly one rising edge.

// File: rtl/uart_irq_ctx_pkg.sv
package uart_irq_ctx_pkg;

   localparam int BYTE_W = 8;

   typedef enum logic [2:0] {
      SEL_VEC   = 3'd0,
      SEL_CHAN  = 3'd1,
      SEL_TYPE  = 3'd2,
      SEL_COUNT = 3'd3,
      SEL_RXQ   = 3'd4,
      SEL_TXQ   = 3'd5
   } reg_sel_e;

   typedef struct packed {
      logic       rx_hit;    // receiver interrupt
      logic       rx_clean;  // receiver without errors
      logic       tx_hit;    // transmitter interrupt
      logic [1:0] resv;      // always zero once captured
      logic [2:0] misc;      // other-type code
   } irq_type_t;

   function automatic logic is_data(irq_type_t t);
      return t.rx_hit | t.tx_hit;
   endfunction

   function automatic logic [1:0] vec_code(irq_type_t t);
      if (t.rx_hit)      return {1'b1, t.rx_clean};
      else if (t.tx_hit) return 2'b01;
      else               return 2'b00;
   endfunction

endpackage

// File: rtl/irq_ctx_capture.sv
module irq_ctx_capture
   import uart_irq_ctx_pkg::*;
#(
   parameter  int NUM_CH     = 2,
   parameter  int FIFO_DEPTH = 256,
   localparam int CH_W       = $clog2(NUM_CH),
   localparam int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              take,
   input  logic [CH_W-1:0]   win_ch,
   input  logic [BYTE_W-1:0] win_type,
   input  logic [LVL_W-1:0]  win_level,
   output logic [CH_W-1:0]   ctx_ch,
   output irq_type_t         ctx_type,
   output logic [BYTE_W-1:0] ctx_count
);

   irq_type_t         type_in;
   logic [BYTE_W-1:0] count_in;

   always_comb begin
      type_in      = irq_type_t'(win_type);
      type_in.resv = 2'b00;
      if (!is_data(type_in))
         count_in = '0;
      else if (win_level == LVL_W'(FIFO_DEPTH))
         count_in = BYTE_W'(FIFO_DEPTH % (1 << BYTE_W));
      else
         count_in = BYTE_W'(win_level);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctx_ch    <= '0;
         ctx_type  <= '0;
         ctx_count <= '0;
      end else if (take) begin
         ctx_ch    <= win_ch;
         ctx_type  <= type_in;
         ctx_count <= count_in;
      end
   end

   assert_ctx_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !take |=> ($stable(ctx_ch) && $stable(ctx_type) && $stable(ctx_count)));

   assert_ctx_take_R4: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> (ctx_ch == $past(win_ch)));

   assert_count_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (take && win_level == LVL_W'(FIFO_DEPTH) && FIFO_DEPTH == 256)
      |=> (ctx_count == 8'h00));

   assert_resv_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> (ctx_type.resv == 2'b00));

endmodule

// File: rtl/irq_vec_modify.sv
module irq_vec_modify
   import uart_irq_ctx_pkg::*;
(
   input  logic              active,
   input  logic [BYTE_W-1:0] base_vec,
   input  logic [1:0]        ivc,
   input  logic              ch_bit,
   input  logic [1:0]        code,
   output logic [BYTE_W-1:0] vec
);

   logic [BYTE_W-1:0] mod;

   always_comb begin
      mod = base_vec;
      if (ivc > 2'd1)  mod[0]   = ch_bit;
      if (ivc == 2'd3) mod[2:1] = code;
      vec = active ? mod : '0;
   end

   always_comb begin
      assert_vec_upper_R1: assert (!active || vec[7:3] == base_vec[7:3]);
      assert_vec_plain_R1: assert (!active || ivc > 2'd1 || vec == base_vec);
      assert_vec_chan_R2:  assert (!active || ivc < 2'd2 || vec[0] == ch_bit);
   end

endmodule

// File: rtl/irq_fifo_route.sv
module irq_fifo_route
   import uart_irq_ctx_pkg::*;
#(
   parameter  int NUM_CH = 2,
   localparam int CH_W   = $clog2(NUM_CH)
) (
   input  logic [CH_W-1:0]          ctx_ch,
   input  logic                     ctx_rx,
   input  logic                     rd_req,
   input  logic                     wr_req,
   input  logic [BYTE_W-1:0]        wdata,
   input  logic [NUM_CH*BYTE_W-1:0] rxq_data,
   output logic [NUM_CH-1:0]        rxq_pop,
   output logic [NUM_CH-1:0]        txq_push,
   output logic [BYTE_W-1:0]        txq_data,
   output logic [BYTE_W-1:0]        rd_data
);

   logic [BYTE_W-1:0] lane [NUM_CH];

   for (genvar i = 0; i < NUM_CH; i++) begin : g_lane
      assign lane[i]     = rxq_data[i*BYTE_W +: BYTE_W];
      assign rxq_pop[i]  = rd_req && ctx_rx && (ctx_ch == CH_W'(i));
      assign txq_push[i] = wr_req && (ctx_ch == CH_W'(i));
   end

   assign txq_data = wdata;
   assign rd_data  = ctx_rx ? lane[ctx_ch] : '0;

   always_comb begin
      assert_pop_onehot_R9:  assert ($onehot0(rxq_pop));
      assert_push_onehot_R8: assert ($onehot0(txq_push));
      assert_pop_ctx_R9:     assert (rxq_pop == '0 || ctx_rx);
      assert_push_req_R8:    assert (wr_req == (txq_push != '0));
   end

endmodule

// File: rtl/uart_irq_ctx.sv
module uart_irq_ctx
   import uart_irq_ctx_pkg::*;
#(
   parameter  int                NUM_CH     = 2,
   parameter  int                FIFO_DEPTH = 256,
   parameter  logic [BYTE_W-1:0] VEC_RST    = 8'h0F,
   localparam int                CH_W       = $clog2(NUM_CH),
   localparam int                LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [CH_W-1:0]          win_ch,
   input  logic [BYTE_W-1:0]        win_type,
   input  logic [LVL_W-1:0]         win_level,
   input  logic                     iack,
   input  logic                     upd,
   input  logic [1:0]               ivc_cfg,
   output logic [BYTE_W-1:0]        vec_out,
   output logic                     vec_drive,
   input  logic [2:0]               reg_sel,
   input  logic                     reg_rd,
   input  logic                     reg_wr,
   input  logic [BYTE_W-1:0]        reg_wdata,
   output logic [BYTE_W-1:0]        reg_rdata,
   input  logic [NUM_CH*BYTE_W-1:0] rxq_data,
   output logic [NUM_CH-1:0]        rxq_pop,
   output logic [NUM_CH-1:0]        txq_push,
   output logic [BYTE_W-1:0]        txq_data
);

   if (NUM_CH < 2 || NUM_CH > 128 || (NUM_CH & (NUM_CH - 1)) != 0) begin : g_bad_ch
      $error("NUM_CH must be a power of two between 2 and 128");
   end
   if (FIFO_DEPTH < 1 || FIFO_DEPTH > 256) begin : g_bad_depth
      $error("FIFO_DEPTH must lie in 1..256");
   end

   logic [BYTE_W-1:0] base_vec;
   logic [CH_W-1:0]   ctx_ch;
   irq_type_t         ctx_type;
   logic [BYTE_W-1:0] ctx_count;
   logic [BYTE_W-1:0] rxq_rd_data;
   logic              rd_rxq, wr_txq, wr_vec;

   assign wr_vec = reg_wr && (reg_sel == SEL_VEC);
   assign rd_rxq = reg_rd && (reg_sel == SEL_RXQ);
   assign wr_txq = reg_wr && (reg_sel == SEL_TXQ);

   always_ff @(posedge clk) begin
      if (!rst_n)      base_vec <= VEC_RST;
      else if (wr_vec) base_vec <= reg_wdata;
   end

   irq_ctx_capture #(.NUM_CH(NUM_CH), .FIFO_DEPTH(FIFO_DEPTH)) u_cap (
      .clk       (clk),
      .rst_n     (rst_n),
      .take      (iack || upd),
      .win_ch    (win_ch),
      .win_type  (win_type),
      .win_level (win_level),
      .ctx_ch    (ctx_ch),
      .ctx_type  (ctx_type),
      .ctx_count (ctx_count)
   );

   irq_vec_modify u_vec (
      .active   (iack),
      .base_vec (base_vec),
      .ivc      (ivc_cfg),
      .ch_bit   (win_ch[0]),
      .code     (vec_code(irq_type_t'(win_type))),
      .vec      (vec_out)
   );

   assign vec_drive = iack;

   irq_fifo_route #(.NUM_CH(NUM_CH)) u_route (
      .ctx_ch   (ctx_ch),
      .ctx_rx   (ctx_type.rx_hit),
      .rd_req   (rd_rxq),
      .wr_req   (wr_txq),
      .wdata    (reg_wdata),
      .rxq_data (rxq_data),
      .rxq_pop  (rxq_pop),
      .txq_push (txq_push),
      .txq_data (txq_data),
      .rd_data  (rxq_rd_data)
   );

   always_comb begin
      case (reg_sel_e'(reg_sel))
         SEL_VEC:   reg_rdata = base_vec;
         SEL_CHAN:  reg_rdata = BYTE_W'(ctx_ch);
         SEL_TYPE:  reg_rdata = ctx_type;
         SEL_COUNT: reg_rdata = ctx_count;
         SEL_RXQ:   reg_rdata = rxq_rd_data;
         default:   reg_rdata = '0;
      endcase
   end

   assert_vec_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !iack |-> (vec_out == 8'h00));

   assert_chan_upper_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_sel == 3'd1) |-> (reg_rdata[BYTE_W-1:CH_W] == '0));

   assert_vec_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
      wr_vec |=> (base_vec == $past(reg_wdata)));

   assert_nondata_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (upd && !win_type[7] && !win_type[5]) |=> (ctx_count == 8'h00));

endmodule

// File: tb/tb_uart_irq_ctx.sv
module tb_uart_irq_ctx;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [0:0]  win_ch = '0;
   logic [7:0]  win_type = '0;
   logic [8:0]  win_level = '0;
   logic        iack = 1'b0, upd = 1'b0;
   logic [1:0]  ivc_cfg = '0;
   logic [7:0]  vec_out;
   logic        vec_drive;
   logic [2:0]  reg_sel = '0;
   logic        reg_rd = 1'b0, reg_wr = 1'b0;
   logic [7:0]  reg_wdata = '0;
   logic [7:0]  reg_rdata;
   logic [15:0] rxq_data = {8'hB1, 8'hA0};
   logic [1:0]  rxq_pop, txq_push;
   logic [7:0]  txq_data;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   uart_irq_ctx dut (
      .clk(clk), .rst_n(rst_n), .win_ch(win_ch), .win_type(win_type),
      .win_level(win_level), .iack(iack), .upd(upd), .ivc_cfg(ivc_cfg),
      .vec_out(vec_out), .vec_drive(vec_drive), .reg_sel(reg_sel),
      .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .rxq_data(rxq_data), .rxq_pop(rxq_pop),
      .txq_push(txq_push), .txq_data(txq_data)
   );

   task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] exp_vec(logic [7:0] base, logic [1:0] ivc,
                                          logic ch, logic [7:0] t);
      logic [7:0] v = base;
      logic [1:0] c = t[7] ? {1'b1, t[6]} : (t[5] ? 2'b01 : 2'b00);
      if (ivc >= 2) v[0] = ch;
      if (ivc == 3) v[2:1] = c;
      return v;
   endfunction

   task automatic rd_reg(logic [2:0] a, output logic [7:0] d);
      @(negedge clk);
      reg_sel = a;
      #1 d = reg_rdata;
   endtask

   task automatic set_win(logic ch, logic [7:0] t, logic [8:0] lvl);
      @(negedge clk);
      win_ch = ch; win_type = t; win_level = lvl;
   endtask

   task automatic pulse_upd();
      @(negedge clk); upd = 1'b1;
      @(negedge clk); upd = 1'b0;
   endtask

   task automatic t_reset();
      logic [7:0] d;
      rd_reg(3'd0, d); chk("R11 vector reset", d, 8'h0F);
      rd_reg(3'd1, d); chk("R11 channel reset", d, 8'h00);
      rd_reg(3'd2, d); chk("R11 type reset", d, 8'h00);
      rd_reg(3'd3, d); chk("R11 count reset", d, 8'h00);
      chk("R1 idle vector", vec_out, 8'h00);
   endtask

   task automatic t_vec_reg();
      logic [7:0] d;
      @(negedge clk); reg_sel = 3'd0; reg_wdata = 8'hA5; reg_wr = 1'b1;
      @(negedge clk); reg_wr = 1'b0;
      rd_reg(3'd0, d); chk("R10 vector write", d, 8'hA5);
      rd_reg(3'd6, d); chk("R10 unused address", d, 8'h00);
      rd_reg(3'd7, d); chk("R10 unused address", d, 8'h00);
   endtask

   task automatic t_vec_modes();
      logic [7:0] types [4] = '{8'h80, 8'hC0, 8'h20, 8'h03};
      logic [7:0] d;
      for (int m = 0; m < 4; m++) begin
         for (int c = 0; c < 2; c++) begin
            for (int k = 0; k < 4; k++) begin
               set_win(c[0], types[k], 9'd3);
               ivc_cfg = m[1:0];
               @(negedge clk); iack = 1'b1;
               #1 chk(m < 2 ? "R1 vector" : (m == 2 ? "R2 vector" : "R3 vector"),
                      vec_out, exp_vec(8'hA5, m[1:0], c[0], types[k]));
               chk("R1 drive", vec_drive, 1'b1);
               @(negedge clk); iack = 1'b0;
               rd_reg(3'd1, d); chk("R5 channel", d, {7'd0, c[0]});
            end
         end
      end
   endtask

   task automatic t_types();
      logic [7:0] d;
      for (int o = 0; o < 8; o++) begin
         set_win(o[0], {5'b00011, o[2:0]}, 9'd9);
         pulse_upd();
         rd_reg(3'd2, d); chk("R6 type other", d, {5'b00000, o[2:0]});
         rd_reg(3'd1, d); chk("R5 channel", d, {7'd0, o[0]});
      end
      set_win(1'b0, 8'hD8, 9'd9);
      pulse_upd();
      rd_reg(3'd2, d); chk("R6 rx clean reserved masked", d, 8'hC0);
   endtask

   task automatic t_count();
      logic [7:0] d;
      set_win(1'b0, 8'h80, 9'd256); pulse_upd();
      rd_reg(3'd3, d); chk("R7 count 256", d, 8'h00);
      set_win(1'b1, 8'h20, 9'd255); pulse_upd();
      rd_reg(3'd3, d); chk("R7 count 255", d, 8'hFF);
      set_win(1'b1, 8'hC0, 9'd1); pulse_upd();
      rd_reg(3'd3, d); chk("R7 count 1", d, 8'h01);
      set_win(1'b0, 8'h05, 9'd37); pulse_upd();
      rd_reg(3'd3, d); chk("R7 non-data count", d, 8'h00);
   endtask

   task automatic t_hold();
      logic [7:0] d;
      set_win(1'b1, 8'h80, 9'd12); pulse_upd();
      set_win(1'b0, 8'h06, 9'd200);
      repeat (3) @(negedge clk);
      rd_reg(3'd1, d); chk("R4 hold channel", d, 8'h01);
      rd_reg(3'd2, d); chk("R4 hold type", d, 8'h80);
      rd_reg(3'd3, d); chk("R4 hold count", d, 8'h0C);
   endtask

   task automatic t_route();
      set_win(1'b1, 8'h20, 9'd5); pulse_upd();
      @(negedge clk); reg_sel = 3'd5; reg_wdata = 8'h3C; reg_wr = 1'b1;
      #1 chk("R8 push ch b", txq_push, 2'b10);
      chk("R8 push data", txq_data, 8'h3C);
      #1 reg_wr = 1'b0;
      set_win(1'b0, 8'hC0, 9'd4); pulse_upd();
      set_win(1'b1, 8'h80, 9'd4);
      @(negedge clk); reg_sel = 3'd4; reg_rd = 1'b1;
      #1 chk("R9 pop ch a", rxq_pop, 2'b01);
      chk("R9 data ch a", reg_rdata, 8'hA0);
      #1 reg_rd = 1'b0;
      @(negedge clk); reg_sel = 3'd5; reg_wr = 1'b1; reg_wdata = 8'h77;
      #1 chk("R8 push ch a", txq_push, 2'b01);
      #1 reg_wr = 1'b0;
      pulse_upd();
      @(negedge clk); reg_sel = 3'd4; reg_rd = 1'b1;
      #1 chk("R9 pop ch b", rxq_pop, 2'b10);
      chk("R9 data ch b", reg_rdata, 8'hB1);
      #1 reg_rd = 1'b0;
      set_win(1'b1, 8'h20, 9'd4); pulse_upd();
      @(negedge clk); reg_sel = 3'd4; reg_rd = 1'b1;
      #1 chk("R9 non-rx pop", rxq_pop, 2'b00);
      chk("R9 non-rx data", reg_rdata, 8'h00);
      #1 reg_rd = 1'b0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_vec_reg();
      t_vec_modes();
      t_types();
      t_count();
      t_hold();
      t_route();
      repeat (2) @(negedge clk);
      finish_run();
   end

   initial begin
      repeat (50000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      finish_run();
   end

endmodule